// File: doc/BRIEF.md
# Bit-banged serial configuration EEPROM responder

This block stands in for a small serial configuration memory that host software reads one bit at a time. Software writes a control register whose fields carry a clock bit, a data-in bit, a request bit and, read back, a data-out bit and a grant bit. A 0-to-1 change of the clock bit between two consecutive writes is one serial clock edge. On each such edge the responder samples data-in.

A command starts with an 8-bit opcode. A read command is followed by an 8-bit byte address, and the responder then shifts the addressed 16-bit word out on data-out, one bit per edge. A read-status command returns eight zero bits. After either command the responder is ready for the next one.

The image holds 64 words. Words 0 to 2 carry the station MAC address. The last word is a checksum chosen so that all 64 words add up to 16'hBABA, modulo 2^16. Every other word is zero.

Control register bit positions: bit 0 clock, bit 1 data-in, bit 2 data-out (read-only), bit 3 request, bit 4 grant (read-only).

Top module: `cfg_eeprom_responder`

## Requirements
- R1: After reset, rd_data is 5'b00000 and err is 0.
- R2: On every write, the grant field (bit 4) takes the value written to the request field (bit 3). Reads show it one cycle after the write.
- R3: Bit 2 of a write is ignored. The data-out field changes only on a serial clock edge.
- R4: A sample is taken only when a write sets bit 0 to 1 while the previous written value of bit 0 was 0. Writes with bit 0 held at 1, and cycles without a write, sample nothing.
- R5: The first 8 samples form the opcode, MSB first. For opcode 8'h03 the next 8 samples form a byte address, MSB first, and the word index is that address shifted right by one. The next 16 edges each set data-out to one bit of that word, MSB first.
- R6: Word 0 holds MAC[47:32], word 1 holds MAC[31:16] and word 2 holds MAC[15:0]. Words 3 to 62 are zero. Word 63 makes the 16-bit sum of all 64 words equal 16'hBABA.
- R7: For opcode 8'h05, each of the next 8 edges sets data-out to 0.
- R8: After the last data bit of a command, the opcode, the address and all bit counts return to zero, so a new command can follow at once.
- R9: An opcode other than 8'h03 or 8'h05 sets err. The command is dropped and the responder waits for a new opcode.
- R10: A read address whose word index is 64 or more sets err. That command returns no data, leaves data-out unchanged and returns the responder to the opcode phase.
- R11: Once set, err stays 1 until reset, and commands keep working while it is set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Control register write strobe |
| wr_data | input | 5 | Value written to the control register |
| rd_data | output | 5 | Control register read value |
| err | output | 1 | Sticky protocol error flag |

## Verification
Reads are tried at even and odd byte addresses, at the MAC words and at the checksum word, and then across the whole image. This separates a wrong word index from a wrong bit order and shows whether the checksum rule holds. Commands are sent with extra writes that hold the clock bit high and that flip data-in. This separates true edge detection from level sampling. A read-status command is sent just before a read to show that counters clear between commands. Unknown opcodes and out-of-range addresses are each followed by a good read. This shows that err stays set while the responder recovers.

// File: rtl/eeprom_resp_pkg.sv
// Shared constants for the serial EEPROM responder: control field
// positions, command codes and the image sum target.
package eeprom_resp_pkg;
    localparam int CTRL_W   = 5;
    localparam int FLD_CLK  = 0;
    localparam int FLD_DIN  = 1;
    localparam int FLD_DOUT = 2;
    localparam int FLD_REQ  = 3;
    localparam int FLD_GNT  = 4;
    localparam int OP_BITS  = 8;
    localparam logic [OP_BITS-1:0] OP_READ   = 8'h03;
    localparam logic [OP_BITS-1:0] OP_STATUS = 8'h05;
    localparam logic [15:0] SUM_TARGET = 16'hBABA;

    typedef enum logic [1:0] {PH_OP, PH_ADDR, PH_DATA} phase_t;
endpackage

// File: rtl/eeprom_image.sv
// Read-only image of the EEPROM. Words 0..2 hold the MAC and the last word
// holds the checksum. Assumes WORDS >= 4 and a 16-bit word for the checksum rule.
module eeprom_image #(
    parameter int WORD_W = 16,
    parameter int WORDS  = 64,
    parameter logic [3*WORD_W-1:0] MAC = 48'h0012_3456_789A,
    localparam int IDX_W = $clog2(WORDS)
) (
    input  logic [IDX_W-1:0]  idx,
    output logic [WORD_W-1:0] word
);
    import eeprom_resp_pkg::*;

    localparam logic [WORD_W-1:0] CSUM = WORD_W'(SUM_TARGET)
        - MAC[3*WORD_W-1:2*WORD_W] - MAC[2*WORD_W-1:WORD_W] - MAC[WORD_W-1:0];

    logic [WORD_W-1:0] image [WORDS];

    // Build each word of the image from the MAC, zero fill, or checksum.
    for (genvar i = 0; i < WORDS; i++) begin : g_word
        if (i == WORDS - 1) begin : g_sum
            assign image[i] = CSUM;
        end else if (i < 3) begin : g_mac
            assign image[i] = MAC[3*WORD_W-1-WORD_W*i -: WORD_W];
        end else begin : g_zero
            assign image[i] = '0;
        end
    end

    // Select the addressed word.
    assign word = image[idx];
endmodule

// File: rtl/eeprom_seq.sv
// Serial command sequencer: opcode, address and data phases, one step per
// sampled clock edge. Assumes a single-cycle sample strobe from the register.
module eeprom_seq #(
    parameter int WORD_W    = 16,
    parameter int WORDS     = 64,
    parameter int ADDR_BITS = 8,
    parameter int STAT_BITS = 8,
    localparam int IDX_W = $clog2(WORDS),
    localparam int CNT_W = $clog2(WORD_W) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sample,
    input  logic              din,
    input  logic [WORD_W-1:0] word,
    output logic [IDX_W-1:0]  idx,
    output logic              dout,
    output logic              err
);
    import eeprom_resp_pkg::*;

    phase_t               phase;
    logic [CNT_W-1:0]     cnt;
    logic [OP_BITS-1:0]   op_sr;
    logic [ADDR_BITS-1:0] addr_sr;
    logic [OP_BITS-1:0]   op_nxt;
    logic [ADDR_BITS-1:0] addr_nxt;
    logic [CNT_W-1:0]     data_last;

    // Next shift values and the last data bit count for the current command.
    always_comb begin
        op_nxt    = {op_sr[OP_BITS-2:0], din};
        addr_nxt  = {addr_sr[ADDR_BITS-2:0], din};
        data_last = (op_sr == OP_READ) ? CNT_W'(WORD_W - 1) : CNT_W'(STAT_BITS - 1);
    end

    assign idx = addr_sr[IDX_W:1];

    // Advance the command state on each sampled edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase   <= PH_OP;
            cnt     <= '0;
            op_sr   <= '0;
            addr_sr <= '0;
            dout    <= 1'b0;
            err     <= 1'b0;
        end else if (sample) begin
            case (phase)
                PH_OP: begin
                    if (cnt == CNT_W'(OP_BITS - 1)) begin
                        cnt <= '0;
                        if (op_nxt == OP_READ) begin
                            op_sr <= op_nxt;
                            phase <= PH_ADDR;
                        end else if (op_nxt == OP_STATUS) begin
                            op_sr <= op_nxt;
                            phase <= PH_DATA;
                        end else begin
                            op_sr <= '0;
                            err   <= 1'b1;
                        end
                    end else begin
                        op_sr <= op_nxt;
                        cnt   <= cnt + 1'b1;
                    end
                end
                PH_ADDR: begin
                    if (cnt == CNT_W'(ADDR_BITS - 1)) begin
                        cnt <= '0;
                        if (int'(addr_nxt[ADDR_BITS-1:1]) >= WORDS) begin
                            err     <= 1'b1;
                            op_sr   <= '0;
                            addr_sr <= '0;
                            phase   <= PH_OP;
                        end else begin
                            addr_sr <= addr_nxt;
                            phase   <= PH_DATA;
                        end
                    end else begin
                        addr_sr <= addr_nxt;
                        cnt     <= cnt + 1'b1;
                    end
                end
                default: begin
                    dout <= (op_sr == OP_READ) ? word[WORD_W-1-int'(cnt)] : 1'b0;
                    if (cnt == data_last) begin
                        cnt     <= '0;
                        op_sr   <= '0;
                        addr_sr <= '0;
                        phase   <= PH_OP;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
            endcase
        end
    end
endmodule

// File: rtl/cfg_eeprom_responder.sv
// Top of the serial EEPROM responder: holds the software control register,
// detects rising edges of its clock bit and joins the sequencer to the image.
// Assumes all access is whole-register writes with a combinational read.
module cfg_eeprom_responder #(
    parameter int WORD_W    = 16,
    parameter int WORDS     = 64,
    parameter int ADDR_BITS = 8,
    parameter int STAT_BITS = 8,
    parameter logic [3*WORD_W-1:0] MAC = 48'h0012_3456_789A,
    localparam int CW = eeprom_resp_pkg::CTRL_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [CW-1:0] wr_data,
    output logic [CW-1:0] rd_data,
    output logic          err
);
    import eeprom_resp_pkg::*;

    localparam int IDX_W = $clog2(WORDS);

    logic              sk_q, din_q, req_q, gnt_q;
    logic              sample;
    logic              dout;
    logic [IDX_W-1:0]  idx;
    logic [WORD_W-1:0] word;

    assign sample = wr_en && wr_data[FLD_CLK] && !sk_q;

    // Capture the writable fields; grant copies request on each write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sk_q  <= 1'b0;
            din_q <= 1'b0;
            req_q <= 1'b0;
            gnt_q <= 1'b0;
        end else if (wr_en) begin
            sk_q  <= wr_data[FLD_CLK];
            din_q <= wr_data[FLD_DIN];
            req_q <= wr_data[FLD_REQ];
            gnt_q <= wr_data[FLD_REQ];
        end
    end

    // Assemble the register read value.
    always_comb begin
        rd_data           = '0;
        rd_data[FLD_CLK]  = sk_q;
        rd_data[FLD_DIN]  = din_q;
        rd_data[FLD_DOUT] = dout;
        rd_data[FLD_REQ]  = req_q;
        rd_data[FLD_GNT]  = gnt_q;
    end

    eeprom_image #(.WORD_W(WORD_W), .WORDS(WORDS), .MAC(MAC)) u_image (
        .idx  (idx),
        .word (word)
    );

    eeprom_seq #(.WORD_W(WORD_W), .WORDS(WORDS), .ADDR_BITS(ADDR_BITS),
                 .STAT_BITS(STAT_BITS)) u_seq (
        .clk    (clk),
        .rst_n  (rst_n),
        .sample (sample),
        .din    (wr_data[FLD_DIN]),
        .word   (word),
        .idx    (idx),
        .dout   (dout),
        .err    (err)
    );
endmodule

// File: rtl/cfg_eeprom_responder_chk.sv
// Port-level protocol checks for the EEPROM responder, bound to every instance.
module cfg_eeprom_responder_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       wr_en,
    input logic [4:0] wr_data,
    input logic [4:0] rd_data,
    input logic       err
);
    // R2: grant reflects the request bit of the previous write.
    assert_grant_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> rd_data[4] == $past(wr_data[3]));

    // R3 / R4: data-out holds unless a write makes a rising clock edge.
    assert_dout_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && wr_data[0] && !rd_data[0]) |=> $stable(rd_data[2]));

    // R2: without a write the register read value holds.
    assert_reg_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(rd_data));

    // R11: the error flag never drops outside reset.
    assert_err_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> err);
endmodule

bind cfg_eeprom_responder cfg_eeprom_responder_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .rd_data (rd_data),
    .err     (err)
);

// File: tb/cfg_eeprom_responder_test.sv
// Directed bench for the EEPROM responder: one task per scenario.
module cfg_eeprom_responder_test;
    localparam logic [47:0] MAC = 48'h0012_3456_789A;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [4:0] wr_data = '0;
    logic [4:0] rd_data;
    logic       err;
    int         n_chk = 0;
    int         n_bad = 0;
    logic       req_v = 1'b0;

    always #2 clk = ~clk;

    cfg_eeprom_responder uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .err(err)
    );

    function automatic logic [15:0] exp_word(int i);
        logic [15:0] s;
        if (i == 0) return MAC[47:32];
        if (i == 1) return MAC[31:16];
        if (i == 2) return MAC[15:0];
        if (i == 63) begin
            s = 16'hBABA - MAC[47:32] - MAC[31:16] - MAC[15:0];
            return s;
        end
        return 16'h0000;
    endfunction

    task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic put(logic sk, logic din, logic dout_w = 1'b0);
        @(negedge clk);
        wr_en = 1'b1;
        wr_data = {1'b0, req_v, dout_w, din, sk};
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic send_bits(logic [7:0] v);
        for (int i = 7; i >= 0; i--) begin
            put(1'b0, v[i]);
            put(1'b1, v[i]);
        end
    endtask

    task automatic clock_out(int n, output logic [15:0] v);
        v = '0;
        for (int i = 0; i < n; i++) begin
            put(1'b0, 1'b0);
            put(1'b1, 1'b0);
            v = {v[14:0], rd_data[2]};
        end
    endtask

    task automatic read_addr(logic [7:0] a, output logic [15:0] v);
        send_bits(8'h03);
        send_bits(a);
        clock_out(16, v);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        wr_en = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_reset();
        do_reset();
        check("R1 rd_data", 32'(rd_data), 32'h0);
        check("R1 err", 32'(err), 32'h0);
    endtask

    task automatic t_grant();
        req_v = 1'b1;
        put(1'b0, 1'b0);
        check("R2 grant set", 32'(rd_data[4]), 32'h1);
        req_v = 1'b0;
        put(1'b0, 1'b0);
        check("R2 grant clear", 32'(rd_data[4]), 32'h0);
    endtask

    task automatic t_reads();
        logic [15:0] v;
        read_addr(8'h00, v);
        check("R5 R6 word0", 32'(v), 32'(exp_word(0)));
        read_addr(8'h03, v);
        check("R5 odd addr word1", 32'(v), 32'(exp_word(1)));
        read_addr(8'h05, v);
        check("R5 R6 word2", 32'(v), 32'(exp_word(2)));
        read_addr(8'h7E, v);
        check("R6 checksum word63", 32'(v), 32'(exp_word(63)));
        read_addr(8'h20, v);
        check("R6 zero word16", 32'(v), 32'h0);
    endtask

    task automatic t_sum();
        logic [15:0] v;
        logic [15:0] s = '0;
        for (int i = 0; i < 64; i++) begin
            read_addr(8'(2 * i), v);
            s = s + v;
        end
        check("R6 image sum", 32'(s), 32'hBABA);
    endtask

    task automatic t_status();
        logic [15:0] v;
        logic [15:0] w;
        read_addr(8'h05, w);
        send_bits(8'h05);
        clock_out(8, v);
        check("R7 status bits", 32'(v), 32'h0);
        read_addr(8'h01, v);
        check("R8 read after status", 32'(v), 32'(exp_word(0)));
    endtask

    task automatic t_dout_ignored();
        logic d0;
        d0 = rd_data[2];
        put(1'b0, 1'b0, ~d0);
        check("R3 dout not writable", 32'(rd_data[2]), 32'(d0));
    endtask

    task automatic t_level();
        logic [15:0] v;
        logic [7:0] op = 8'h03;
        logic [7:0] ad = 8'h02;
        for (int i = 7; i >= 0; i--) begin
            put(1'b0, op[i]);
            put(1'b1, op[i]);
            put(1'b1, ~op[i]);
            put(1'b1, ~op[i]);
        end
        for (int i = 7; i >= 0; i--) begin
            put(1'b0, ad[i]);
            put(1'b1, ad[i]);
            put(1'b1, ~ad[i]);
        end
        clock_out(16, v);
        check("R4 held clock bit", 32'(v), 32'(exp_word(1)));
    endtask

    task automatic t_bad_addr();
        logic [15:0] w;
        logic [15:0] v;
        logic d0;
        read_addr(8'h04, w);
        d0 = rd_data[2];
        check("R10 err before", 32'(err), 32'h0);
        send_bits(8'h03);
        send_bits(8'h80);
        check("R10 err set", 32'(err), 32'h1);
        check("R10 dout unchanged", 32'(rd_data[2]), 32'(d0));
        read_addr(8'h05, v);
        check("R11 read after error", 32'(v), 32'(exp_word(2)));
        check("R11 err sticky", 32'(err), 32'h1);
        do_reset();
        check("R11 err cleared by reset", 32'(err), 32'h0);
    endtask

    task automatic t_bad_op();
        logic [15:0] v;
        send_bits(8'hFF);
        check("R9 bad opcode err", 32'(err), 32'h1);
        read_addr(8'h00, v);
        check("R9 recovery read", 32'(v), 32'(exp_word(0)));
    endtask

    initial begin
        t_reset();
        t_grant();
        t_reads();
        t_status();
        t_dout_ignored();
        t_level();
        t_sum();
        t_bad_addr();
        t_bad_op();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule